// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides which of N interrupt lines is served next and whether that line may interrupt the handler already running. Each line has a small priority value, where a lower number means more urgent, and a global grouping code splits that value into an upper preemption part and a lower sub-priority part. Among the lines that are both latched pending and enabled, the winner is the one with the smallest full priority value. When two lines have the same value, the lower line index wins. The preemption part alone decides whether the winner may suspend the running handler. The sub-priority part only breaks ties.

A request is latched by a one-cycle pulse on its set line. It stays pending until the arbiter issues a registered take strobe carrying its index, which clears it. Every take pushes the winner's preemption level onto a level stack. An exit pulse pops the stack, so the suspended handler's level becomes the active level again. Software configures the block through a simple write port that holds one priority value per line and the grouping code.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, no line is pending, take_o is low, the level stack is empty (act_valid_o low, act_depth_o 0), every line priority is 0, and the grouping code is 7.
- R2: Among enabled pending lines, the line with the numerically smallest 4-bit priority value, written through prio_we/prio_idx/prio_val, is taken first.
- R3: Among enabled pending lines that share the same priority value, the one with the lowest index is taken.
- R4: A pending line whose en_i bit is 0 is never taken. Its pending bit stays set until the line is enabled and served.
- R5: take_o is high for the cycle after the clock edge at which the decision is registered. In that same cycle, take_vec_o holds the line index and the line's pend_o bit is already clear.
- R6: If the stack is empty, the winner is taken. If it is not empty, the winner is taken only when its preemption level is numerically less than act_level_o. Each take increments act_depth_o and sets act_level_o to the winner's level.
- R7: A winner whose preemption level equals act_level_o is not taken until exits have lowered the stack below that level.
- R8: A smaller sub-priority never causes preemption when the preemption levels are equal.
- R9: An exit pulse with a non-empty stack pops one entry and restores the previous act_level_o. An exit pulse on an empty stack has no effect.
- R10: The preemption level is the priority value with its low (4 - p) bits cleared. Grouping code 7 gives p = 0, and codes 6, 5, 4 and 3 give p = 1, 2, 3 and 4. Codes 0 to 2 act as code 3.
- R11: No take is registered at a clock edge where exit_i is high.
- R12: If a set pulse for a line arrives in the same cycle that the line's take is registered, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | N | One-cycle request pulses, one per line |
| en_i | input | N | Line enables |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | IW | Line index for the priority write |
| prio_val | input | PW | Priority value to write |
| grp_we | input | 1 | Grouping code write strobe |
| grp_code | input | 3 | Grouping code to write |
| exit_i | input | 1 | Handler exit pulse |
| pend_o | output | N | Latched pending bits |
| take_o | output | 1 | Take strobe |
| take_vec_o | output | IW | Index of the line taken |
| act_valid_o | output | 1 | Stack holds at least one level |
| act_level_o | output | PW | Level on top of the stack, 0 when empty |
| act_depth_o | output | DW | Number of stacked levels |

## Verification
If the level stack is corrupted, the effect shows up one take later. Either a request that should nest fails to strobe, or act_level_o and act_depth_o disagree with the sequence of takes and exits just after the next edge. If the pending register is wrong, a line is taken twice, a line is lost, or a disabled line is strobed, and this appears on take_o and pend_o in the cycle after the decision. A wrong grouping mask stays hidden until a nested request arrives whose levels differ only in the bits that the mask drops.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef logic [2:0] grp_code_t;

    localparam grp_code_t GRP_RESET = 3'd7;

    // Number of preemption bits selected by a grouping code, clamped to the field width.
    function automatic int unsigned preempt_bits(input grp_code_t code, input int unsigned pw);
        int unsigned p;
        p = 32'd7 - 32'(code);
        if (p > pw) p = pw;
        return p;
    endfunction

endpackage

// File: rtl/irq_prio_file.sv
module irq_prio_file
    import irq_arb_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prio_we,
    input  logic [IW-1:0]         prio_idx,
    input  logic [PW-1:0]         prio_val,
    input  logic                  grp_we,
    input  grp_code_t             grp_code,
    output logic [N-1:0][PW-1:0]  prio_o,
    output logic [PW-1:0]         lvl_mask_o
);

    typedef struct packed {
        logic [N-1:0][PW-1:0] prio;
        grp_code_t            grp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    int unsigned pbits;

    always_comb begin
        cfg_d = cfg_q;
        if (prio_we && (int'(prio_idx) < int'(N))) begin
            cfg_d.prio[prio_idx] = prio_val;
        end
        if (grp_we) begin
            cfg_d.grp = grp_code;
        end

        pbits = preempt_bits(cfg_q.grp, PW);
        for (int b = 0; b < int'(PW); b++) begin
            lvl_mask_o[b] = (b >= int'(PW) - int'(pbits));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.prio <= '0;
            cfg_q.grp  <= GRP_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign prio_o = cfg_q.prio;

endmodule

// File: rtl/irq_select.sv
module irq_select #(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]          pend_i,
    input  logic [N-1:0]          en_i,
    input  logic [N-1:0][PW-1:0]  prio_i,
    output logic                  hit_o,
    output logic [IW-1:0]         idx_o,
    output logic [PW-1:0]         prio_o
);

    // Full priority compare equals (preempt, sub) lexicographic order; strict
    // less-than keeps the lowest index on ties.
    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        prio_o = '1;
        for (int i = 0; i < int'(N); i++) begin
            if (pend_i[i] && en_i[i]) begin
                if (!hit_o || (prio_i[i] < prio_o)) begin
                    hit_o  = 1'b1;
                    idx_o  = IW'(i);
                    prio_o = prio_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int unsigned PW = 4,
    localparam int unsigned DEPTH = 2 ** PW,
    localparam int unsigned DW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [PW-1:0] push_lvl_i,
    input  logic          pop_i,
    output logic          valid_o,
    output logic [PW-1:0] top_o,
    output logic [DW-1:0] depth_o
);

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] ent;
        logic [DW-1:0]            cnt;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [DW-1:0] top_ptr;

    always_comb begin
        stk_d   = stk_q;
        top_ptr = stk_q.cnt - DW'(1);
        if (push_i && (stk_q.cnt < DW'(DEPTH))) begin
            stk_d.ent[stk_q.cnt[PW-1:0]] = push_lvl_i;
            stk_d.cnt = stk_q.cnt + DW'(1);
        end else if (pop_i && (stk_q.cnt != '0)) begin
            stk_d.cnt = stk_q.cnt - DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign valid_o = (stk_q.cnt != '0);
    assign top_o   = valid_o ? stk_q.ent[top_ptr[PW-1:0]] : '0;
    assign depth_o = stk_q.cnt;

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned DW = $clog2((2 ** PW) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_i,
    input  logic [N-1:0]  en_i,
    input  logic          prio_we,
    input  logic [IW-1:0] prio_idx,
    input  logic [PW-1:0] prio_val,
    input  logic          grp_we,
    input  logic [2:0]    grp_code,
    input  logic          exit_i,
    output logic [N-1:0]  pend_o,
    output logic          take_o,
    output logic [IW-1:0] take_vec_o,
    output logic          act_valid_o,
    output logic [PW-1:0] act_level_o,
    output logic [DW-1:0] act_depth_o
);

    typedef struct packed {
        logic [N-1:0]  pend;
        logic          take;
        logic [IW-1:0] vec;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [N-1:0][PW-1:0] prio;
    logic [PW-1:0]        lvl_mask;
    logic                 win_hit;
    logic [IW-1:0]        win_idx;
    logic [PW-1:0]        win_prio;
    logic [PW-1:0]        win_lvl;
    logic                 can_take;
    logic                 do_pop;
    logic                 stk_valid;
    logic [PW-1:0]        stk_top;
    logic [DW-1:0]        stk_depth;

    irq_prio_file #(.N(N), .PW(PW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we    (prio_we),
        .prio_idx   (prio_idx),
        .prio_val   (prio_val),
        .grp_we     (grp_we),
        .grp_code   (grp_code),
        .prio_o     (prio),
        .lvl_mask_o (lvl_mask)
    );

    irq_select #(.N(N), .PW(PW)) u_sel (
        .pend_i (st_q.pend),
        .en_i   (en_i),
        .prio_i (prio),
        .hit_o  (win_hit),
        .idx_o  (win_idx),
        .prio_o (win_prio)
    );

    irq_level_stack #(.PW(PW)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (can_take),
        .push_lvl_i (win_lvl),
        .pop_i      (do_pop),
        .valid_o    (stk_valid),
        .top_o      (stk_top),
        .depth_o    (stk_depth)
    );

    always_comb begin
        win_lvl  = win_prio & lvl_mask;
        can_take = win_hit && !exit_i && (!stk_valid || (win_lvl < stk_top));
        do_pop   = exit_i && stk_valid;

        st_d      = st_q;
        st_d.take = can_take;
        if (can_take) begin
            st_d.vec = win_idx;
            st_d.pend[win_idx] = 1'b0;
        end
        st_d.pend = st_d.pend | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o      = st_q.pend;
    assign take_o      = st_q.take;
    assign take_vec_o  = st_q.vec;
    assign act_valid_o = stk_valid;
    assign act_level_o = stk_top;
    assign act_depth_o = stk_depth;

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
    parameter int unsigned N  = 8,
    parameter int unsigned PW = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned DEPTH = 2 ** PW,
    localparam int unsigned DW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  set_i,
    input logic [N-1:0]  en_i,
    input logic          exit_i,
    input logic [N-1:0]  pend_o,
    input logic          take_o,
    input logic [IW-1:0] take_vec_o,
    input logic          act_valid_o,
    input logic [PW-1:0] act_level_o,
    input logic [DW-1:0] act_depth_o
);

    logic [N-1:0] en_p, pend_p, set_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_p   <= '0;
            pend_p <= '0;
            set_p  <= '0;
        end else begin
            en_p   <= en_i;
            pend_p <= pend_o;
            set_p  <= set_i;
        end
    end

    AST_TAKE_ENABLED_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (en_p[take_vec_o] && pend_p[take_vec_o])); // R4

    AST_TAKE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !set_p[take_vec_o]) |-> !pend_o[take_vec_o]); // R5

    AST_TAKE_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (act_depth_o == $past(act_depth_o) + DW'(1))); // R6

    AST_NEST_STRICTER: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(act_valid_o)) |-> (act_level_o < $past(act_level_o))); // R7

    AST_EXIT_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(exit_i) && $past(act_valid_o)) |-> (act_depth_o == $past(act_depth_o) - DW'(1))); // R9

    AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && !$past(exit_i)) |-> $stable(act_depth_o)); // R9

    AST_NO_TAKE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exit_i) |-> !take_o); // R11

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        act_depth_o <= DW'(DEPTH)); // R6

endmodule

bind irq_prio_arbiter irq_arb_checker #(.N(N), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (set_i),
    .en_i        (en_i),
    .exit_i      (exit_i),
    .pend_o      (pend_o),
    .take_o      (take_o),
    .take_vec_o  (take_vec_o),
    .act_valid_o (act_valid_o),
    .act_level_o (act_level_o),
    .act_depth_o (act_depth_o)
);

// File: tb/irq_prio_arbiter_test.sv
module irq_prio_arbiter_test;

    localparam int N  = 8;
    localparam int PW = 4;
    localparam int IW = 3;
    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  set_i;
    logic [N-1:0]  en_i;
    logic          prio_we;
    logic [IW-1:0] prio_idx;
    logic [PW-1:0] prio_val;
    logic          grp_we;
    logic [2:0]    grp_code;
    logic          exit_i;
    logic [N-1:0]  pend_o;
    logic          take_o;
    logic [IW-1:0] take_vec_o;
    logic          act_valid_o;
    logic [PW-1:0] act_level_o;
    logic [DW-1:0] act_depth_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_arbiter #(.N(N), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .en_i(en_i),
        .prio_we(prio_we), .prio_idx(prio_idx), .prio_val(prio_val),
        .grp_we(grp_we), .grp_code(grp_code), .exit_i(exit_i),
        .pend_o(pend_o), .take_o(take_o), .take_vec_o(take_vec_o),
        .act_valid_o(act_valid_o), .act_level_o(act_level_o), .act_depth_o(act_depth_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; set_i = '0; en_i = '0; prio_we = 1'b0; prio_idx = '0;
        prio_val = '0; grp_we = 1'b0; grp_code = '0; exit_i = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr_prio(input int idx, input int val);
        prio_we = 1'b1; prio_idx = IW'(idx); prio_val = PW'(val);
        step();
        prio_we = 1'b0;
    endtask

    task automatic wr_grp(input int code);
        grp_we = 1'b1; grp_code = 3'(code);
        step();
        grp_we = 1'b0;
    endtask

    // Pulse set lines for one cycle; returns at the negedge where pend_o shows them.
    task automatic raise(input logic [N-1:0] m);
        set_i = m;
        step();
        set_i = '0;
    endtask

    task automatic leave();
        exit_i = 1'b1;
        step();
        exit_i = 1'b0;
    endtask

    function automatic int mask_of(input int code);
        int p;
        p = 7 - code;
        if (p > PW) p = PW;
        return ((1 << PW) - 1) & ~((1 << (PW - p)) - 1);
    endfunction

    task automatic t_reset();
        do_reset();
        chk_eq("R1", "take_o after reset", int'(take_o), 0);
        chk_eq("R1", "pend_o after reset", int'(pend_o), 0);
        chk_eq("R1", "act_depth_o after reset", int'(act_depth_o), 0);
        chk_eq("R1", "act_valid_o after reset", int'(act_valid_o), 0);
    endtask

    task automatic t_order();
        do_reset();
        wr_prio(3, 2); wr_prio(5, 1); wr_prio(1, 7);
        en_i = '1;
        raise(8'b0010_1010);
        step();
        chk_eq("R2", "take_o for most urgent", int'(take_o), 1);
        chk_eq("R2", "take_vec_o most urgent", int'(take_vec_o), 5);
        chk_eq("R5", "pend_o after take", int'(pend_o), 8'b0000_1010);
        chk_eq("R10", "level under code 7", int'(act_level_o), 0);
        step();
        chk_eq("R10", "no nesting under code 7", int'(take_o), 0);
        chk_eq("R5", "take_o single pulse depth", int'(act_depth_o), 1);
        leave();
        chk_eq("R11", "no take during exit", int'(take_o), 0);
        step();
        chk_eq("R2", "second winner", int'(take_vec_o), 3);
    endtask

    task automatic t_tie();
        do_reset();
        wr_prio(2, 4); wr_prio(6, 4);
        en_i = '1;
        raise(8'b0100_0100);
        step();
        chk_eq("R3", "lowest index on tie", int'(take_vec_o), 2);
        chk_eq("R3", "take_o on tie", int'(take_o), 1);
    endtask

    task automatic t_disable();
        do_reset();
        wr_prio(0, 0); wr_prio(4, 9);
        en_i = 8'b1111_1110;
        raise(8'b0001_0001);
        step();
        chk_eq("R4", "enabled line taken", int'(take_vec_o), 4);
        leave();
        step(); step();
        chk_eq("R4", "disabled line not taken", int'(take_o), 0);
        chk_eq("R4", "disabled line still pending", int'(pend_o[0]), 1);
        en_i = '1;
        step();
        chk_eq("R4", "line taken once enabled", int'(take_o && take_vec_o == 0), 1);
    endtask

    task automatic t_preempt();
        do_reset();
        wr_grp(5);
        wr_prio(1, 8); wr_prio(2, 4);
        en_i = '1;
        raise(8'b0000_0010);
        step();
        chk_eq("R6", "first level", int'(act_level_o), 8);
        raise(8'b0000_0100);
        step();
        chk_eq("R6", "preempting take", int'(take_o && take_vec_o == 2), 1);
        chk_eq("R6", "nested depth", int'(act_depth_o), 2);
        chk_eq("R6", "nested level", int'(act_level_o), 4);
        leave();
        chk_eq("R9", "restored level", int'(act_level_o), 8);
        chk_eq("R9", "depth after pop", int'(act_depth_o), 1);
        leave();
        chk_eq("R9", "empty after second pop", int'(act_valid_o), 0);
    endtask

    task automatic t_equal_wait();
        do_reset();
        wr_grp(5);
        wr_prio(1, 9); wr_prio(2, 8);
        en_i = '1;
        raise(8'b0000_0010);
        step();
        chk_eq("R7", "first take", int'(take_vec_o), 1);
        raise(8'b0000_0100);
        step(); step();
        chk_eq("R8", "smaller sub-priority does not nest", int'(take_o), 0);
        chk_eq("R7", "equal level waits pending", int'(pend_o[2]), 1);
        leave();
        chk_eq("R11", "no take on exit edge", int'(take_o), 0);
        step();
        chk_eq("R7", "served after exit", int'(take_o && take_vec_o == 2), 1);
    endtask

    task automatic t_group();
        int codes[4] = '{6, 4, 3, 1};
        foreach (codes[k]) begin
            int m;
            int nest;
            m = mask_of(codes[k]);
            nest = ((14 & m) < (15 & m)) ? 1 : 0;
            do_reset();
            wr_grp(codes[k]);
            wr_prio(1, 15); wr_prio(2, 14);
            en_i = '1;
            raise(8'b0000_0010);
            step();
            chk_eq("R10", $sformatf("level for code %0d", codes[k]), int'(act_level_o), 15 & m);
            raise(8'b0000_0100);
            step();
            chk_eq("R10", $sformatf("nesting for code %0d", codes[k]), int'(take_o), nest);
            chk_eq("R10", $sformatf("depth for code %0d", codes[k]), int'(act_depth_o), 1 + nest);
        end
    endtask

    task automatic t_exit_block();
        do_reset();
        wr_prio(5, 3);
        en_i = '1;
        exit_i = 1'b1;
        raise(8'b0010_0000);
        step();
        chk_eq("R11", "held exit blocks take", int'(take_o), 0);
        chk_eq("R9", "exit on empty stack ignored", int'(act_depth_o), 0);
        exit_i = 1'b0;
        step();
        chk_eq("R11", "take after exit drops", int'(take_o && take_vec_o == 5), 1);
    endtask

    task automatic t_collide();
        do_reset();
        wr_prio(3, 1);
        en_i = '1;
        raise(8'b0000_1000);
        raise(8'b0000_1000);
        chk_eq("R12", "take with colliding set", int'(take_o && take_vec_o == 3), 1);
        chk_eq("R12", "line stays pending", int'(pend_o[3]), 1);
    endtask

    initial begin
        rst_n = 1'b0; set_i = '0; en_i = '0; prio_we = 1'b0; prio_idx = '0;
        prio_val = '0; grp_we = 1'b0; grp_code = '0; exit_i = 1'b0;
        t_reset();
        t_order();
        t_tie();
        t_disable();
        t_preempt();
        t_equal_wait();
        t_group();
        t_exit_block();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule